// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block sits between a simple synchronous request port and one asynchronous fast-page-mode DRAM holding 4M words of 4 bits. A requester presents a read or write with a 22-bit word address; the controller splits that address into a row and a column, sends them over one shared set of address pins, and drives the strobes (row strobe, column strobe, write enable, output enable) together with the direction of the data bus. Read data comes back with a one-cycle valid strobe.

After reset the controller waits out a power-up pause. It then runs a fixed number of CAS-before-RAS refresh cycles before it accepts any request. In normal operation it keeps the last row open, so a request to the same row only toggles the column strobe. A request to another row first closes the page and satisfies row precharge. A refresh timer asks for a CAS-before-RAS refresh at a fixed interval. A pending refresh closes the open page and blocks new requests until it has been done. A page is also closed before the row strobe could stay low longer than the page-mode limit. Every DRAM timing minimum is a parameter counted in controller clocks.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, all four strobes are high (inactive), the data driver is off, req_ready_o is low and rsp_valid_o is low.
- R2: No row or column strobe falls within the first T_PWRUP clocks after reset is released.
- R3: Exactly INIT_CNT refresh cycles, each with the column strobe falling while the row strobe is high, are issued before req_ready_o first goes high. No row is opened before they are done.
- R4: When the row strobe falls for an access, the address pins carry address bits [21:11]. When the column strobe falls, they carry bits [10:0].
- R5: Writes use early-write timing. Write enable is already low in the cycle before the column strobe falls, and the controller drives the write data when the column strobe falls.
- R6: The output enable of the DRAM is never low while the controller drives the data bus.
- R7: During a read, write enable stays high until after the column strobe has risen. rsp_valid_o is high for exactly one cycle per read.
- R8: Read data is captured only after the latest of three paths has elapsed: column address to data, column strobe fall to data, and column precharge end to data. The captured word equals the last word written to that address.
- R9: A request to the open row causes no new falling edge of the row strobe.
- R10: Before every falling edge of the row strobe, the row strobe has been high for at least T_RP clocks. This includes a page change.
- R11: Once initialisation is complete, a refresh cycle starts at least once every REF_INT clocks plus a bounded slack for the access in flight.
- R12: The row strobe never stays low for more than T_RASP consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid is also high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Word address: row in upper half, column in lower half |
| req_wdata_i | input | 4 | Write data |
| rsp_valid_o | output | 1 | One-cycle strobe for read data |
| rsp_rdata_o | output | 4 | Read data |
| dram_addr_o | output | 11 | Multiplexed row/column address pins |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data to the DRAM |
| dram_dq_oe_o | output | 1 | Controller drives the data bus when high |
| dram_dq_i | input | 4 | Data from the DRAM |

## Verification
The assertions assume that the requester holds req_valid_i and its fields stable until the cycle in which req_ready_o is also high. They also assume that the DRAM timing parameters are at least one clock, with T_RASP larger than one full access plus T_RCD. The bench drives requests only on falling clock edges and releases valid right after acceptance. A behavioural DRAM model returns inverted data until the access time has passed, so any early capture is caught. It uses short power-up, refresh and page-limit parameters that meet those assumptions.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_PWR,    // power-up pause
    ST_RCAS,   // refresh: CAS low, RAS high
    ST_RRAS,   // refresh: CAS and RAS low
    ST_RPRE,   // refresh precharge
    ST_IDLE,
    ST_CLOSE,  // raise RAS, precharge
    ST_ROW,    // row address setup
    ST_RCD,    // RAS low, row hold
    ST_COL,    // column address and command setup
    ST_CAS,    // CAS low
    ST_CPRE    // CAS precharge
  } fpm_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_wait_cnt.sv
module fpm_wait_cnt #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/fpm_ref_tmr.sv
module fpm_ref_tmr #(
  parameter int unsigned INTERVAL = 3906
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int unsigned RW = $clog2(INTERVAL + 1);

  logic [RW-1:0] cnt_q;
  logic          wrap;

  assign wrap = en_i && (cnt_q == RW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (wrap)      cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + 1'b1;
      if (wrap)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux #(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 11
) (
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   col_sel_i,
  output logic [ROW_W-1:0]       pins_o
);
  logic [ROW_W-1:0] col_ext;

  generate
    if (COL_W < ROW_W) begin : g_pad
      assign col_ext = {{(ROW_W-COL_W){1'b0}}, addr_i[COL_W-1:0]};
    end else begin : g_eq
      assign col_ext = addr_i[COL_W-1:0];
    end
  endgenerate

  assign pins_o = col_sel_i ? col_ext : addr_i[ROW_W+COL_W-1:COL_W];
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned DQ_W     = 4,
  parameter int unsigned T_PWRUP  = 25000,
  parameter int unsigned INIT_CNT = 8,
  parameter int unsigned REF_INT  = 3906,
  parameter int unsigned T_RP     = 10,
  parameter int unsigned T_RCD    = 5,
  parameter int unsigned T_ASC    = 1,
  parameter int unsigned T_CAS    = 3,
  parameter int unsigned T_AA     = 7,
  parameter int unsigned T_CAC    = 4,
  parameter int unsigned T_CPA    = 6,
  parameter int unsigned T_CP     = 3,
  parameter int unsigned T_CSR    = 2,
  parameter int unsigned T_RAS    = 12,
  parameter int unsigned T_RASP   = 25000,
  localparam int unsigned COL_W   = ADDR_W / 2,
  localparam int unsigned ROW_W   = ADDR_W - COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DQ_W-1:0]   rsp_rdata_o,
  output logic [ROW_W-1:0]  dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [DQ_W-1:0]   dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DQ_W-1:0]   dram_dq_i
);
  // capture point: column address path is partly covered by the setup phase
  localparam int unsigned T_ACC  = umax(umax(T_CAC, T_CPA), (T_AA > T_ASC) ? T_AA - T_ASC : 1);
  localparam int unsigned T_CASW = umax(T_CAS, T_ACC);
  localparam int unsigned RASP_M = T_ASC + T_CASW + T_CP + 3;
  localparam int unsigned WAIT_W = $clog2(T_PWRUP + T_RAS + T_RP + T_RCD + T_CASW + T_CSR + 64);
  localparam int unsigned LO_W   = $clog2(T_RASP + 2) + 1;
  localparam int unsigned IW     = $clog2(INIT_CNT + 1);

  fpm_state_e        state_q, nxt;
  logic [IW-1:0]     init_left_q;
  logic              page_open_q, miss_pend_q;
  logic [ROW_W-1:0]  open_row_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic              cur_we_q;
  logic [DQ_W-1:0]   cur_wd_q;
  logic [LO_W-1:0]   ras_lo_q;
  logic              wait_done, wait_load;
  logic [WAIT_W-1:0] wait_val;
  logic              ref_pend, ref_ack, rasp_hit, accept, row_hit;
  logic              ras_act, cas_act, col_phase;

  fpm_wait_cnt #(.W(WAIT_W), .RST_VAL(T_PWRUP - 1)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_load),
    .val_i  (wait_val),
    .done_o (wait_done)
  );

  fpm_ref_tmr #(.INTERVAL(REF_INT)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_left_q == '0),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
    .addr_i    (cur_addr_q),
    .col_sel_i (col_phase),
    .pins_o    (dram_addr_o)
  );

  assign rasp_hit    = ras_lo_q >= LO_W'(T_RASP - RASP_M);
  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend && !(page_open_q && rasp_hit);
  assign accept      = req_valid_i && req_ready_o;
  assign row_hit     = page_open_q && (req_addr_i[ADDR_W-1:COL_W] == open_row_q);
  assign ref_ack     = (state_q == ST_IDLE) && (nxt == ST_RCAS);

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_PWR:   if (wait_done) nxt = ST_RCAS;
      ST_RCAS:  if (wait_done) nxt = ST_RRAS;
      ST_RRAS:  if (wait_done) nxt = ST_RPRE;
      ST_RPRE:  if (wait_done) nxt = (init_left_q > IW'(1)) ? ST_RCAS : ST_IDLE;
      ST_IDLE: begin
        if (page_open_q && (ref_pend || rasp_hit)) nxt = ST_CLOSE;
        else if (!page_open_q && ref_pend)        nxt = ST_RCAS;
        else if (accept) begin
          if (!page_open_q) nxt = ST_ROW;
          else              nxt = row_hit ? ST_COL : ST_CLOSE;
        end
      end
      ST_CLOSE: if (wait_done) nxt = miss_pend_q ? ST_ROW : ST_IDLE;
      ST_ROW:   nxt = ST_RCD;
      ST_RCD:   if (wait_done) nxt = ST_COL;
      ST_COL:   if (wait_done) nxt = ST_CAS;
      ST_CAS:   if (wait_done) nxt = ST_CPRE;
      ST_CPRE:  if (wait_done) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    wait_load = (nxt != state_q);
    unique case (nxt)
      ST_RCAS:  wait_val = WAIT_W'(T_CSR - 1);
      ST_RRAS:  wait_val = WAIT_W'(T_RAS - 1);
      ST_RPRE,
      ST_CLOSE: wait_val = WAIT_W'(T_RP - 1);
      ST_RCD:   wait_val = WAIT_W'(T_RCD - 1);
      ST_COL:   wait_val = WAIT_W'(T_ASC - 1);
      ST_CAS:   wait_val = WAIT_W'(T_CASW - 1);
      ST_CPRE:  wait_val = WAIT_W'(T_CP - 1);
      default:  wait_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PWR;
      init_left_q <= IW'(INIT_CNT);
      page_open_q <= 1'b0;
      miss_pend_q <= 1'b0;
      open_row_q  <= '0;
      cur_addr_q  <= '0;
      cur_we_q    <= 1'b0;
      cur_wd_q    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      ras_lo_q    <= '0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_RPRE && wait_done && init_left_q != '0)
        init_left_q <= init_left_q - 1'b1;
      if (accept) begin
        cur_addr_q  <= req_addr_i;
        cur_we_q    <= req_we_i;
        cur_wd_q    <= req_wdata_i;
        miss_pend_q <= page_open_q && !row_hit;
      end
      if (state_q == ST_ROW) begin
        page_open_q <= 1'b1;
        open_row_q  <= cur_addr_q[ADDR_W-1:COL_W];
        miss_pend_q <= 1'b0;
      end
      if (state_q == ST_IDLE && nxt == ST_CLOSE) page_open_q <= 1'b0;
      rsp_valid_o <= (state_q == ST_CAS) && wait_done && !cur_we_q;
      if ((state_q == ST_CAS) && wait_done && !cur_we_q) rsp_rdata_o <= dram_dq_i;
      ras_lo_q <= dram_ras_no ? '0 : ras_lo_q + 1'b1;
    end
  end

  assign col_phase = (state_q == ST_COL) || (state_q == ST_CAS) || (state_q == ST_CPRE);
  assign ras_act   = (state_q == ST_RRAS) || (state_q == ST_RCD) || col_phase ||
                     ((state_q == ST_IDLE) && page_open_q);
  assign cas_act   = (state_q == ST_RCAS) || (state_q == ST_RRAS) || (state_q == ST_CAS);

  assign dram_ras_no  = !ras_act;
  assign dram_cas_no  = !cas_act;
  // write: WE and data held through CAS precharge for hold time
  assign dram_we_no   = !(cur_we_q && col_phase);
  assign dram_dq_oe_o = cur_we_q && col_phase;
  assign dram_dq_o    = cur_wd_q;
  assign dram_oe_no   = !(!cur_we_q && ((state_q == ST_COL) || (state_q == ST_CAS)));
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int unsigned INIT_CNT = 8,
  parameter int unsigned T_PWRUP  = 25000,
  parameter int unsigned REF_INT  = 3906,
  parameter int unsigned T_RP     = 10,
  parameter int unsigned T_RCD    = 5,
  parameter int unsigned T_ASC    = 1,
  parameter int unsigned T_CAS    = 3,
  parameter int unsigned T_CP     = 3,
  parameter int unsigned T_CSR    = 2,
  parameter int unsigned T_RAS    = 12,
  parameter int unsigned T_RASP   = 25000,
  parameter int unsigned T_ACCW   = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic dram_ras_no,
  input logic dram_cas_no,
  input logic dram_we_no,
  input logic dram_oe_no,
  input logic dram_dq_oe_o
);
  localparam int unsigned SLACK = 2 * T_RP + T_RCD + T_ASC + T_CAS + T_ACCW + T_CP +
                                  T_CSR + T_RAS + 8;

  logic [31:0] cbr_n, since_rst, hi_n, lo_n, gap_n;
  logic        ras_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cbr_n <= '0; since_rst <= '0; hi_n <= '0; lo_n <= '0; gap_n <= '0; ras_q <= 1'b1;
    end else begin
      ras_q <= dram_ras_no;
      if (since_rst < T_PWRUP) since_rst <= since_rst + 1;
      hi_n <= dram_ras_no ? hi_n + 1 : '0;
      lo_n <= dram_ras_no ? '0 : lo_n + 1;
      if (ras_q && !dram_ras_no && !dram_cas_no) begin
        if (cbr_n < INIT_CNT) cbr_n <= cbr_n + 1;
        gap_n <= '0;
      end else if (cbr_n >= INIT_CNT) gap_n <= gap_n + 1;
    end
  end

  a_r6_no_bus_fight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dram_oe_no && dram_dq_oe_o));
  a_r5_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && !dram_ras_no && !dram_we_no |-> $past(!dram_we_no) && dram_dq_oe_o);
  a_r7_read_we_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) && !dram_ras_no && $past(!dram_oe_no) |-> dram_we_no);
  a_r3_init_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cbr_n >= INIT_CNT);
  a_r2_pwrup_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) || $fell(dram_cas_no) |-> since_rst >= T_PWRUP);
  a_r10_ras_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> hi_n >= T_RP);
  a_r12_rasp_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_n <= T_RASP);
  a_r11_refresh_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_n >= INIT_CNT |-> gap_n <= REF_INT + SLACK);
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
  .INIT_CNT(INIT_CNT), .T_PWRUP(T_PWRUP), .REF_INT(REF_INT), .T_RP(T_RP),
  .T_RCD(T_RCD), .T_ASC(T_ASC), .T_CAS(T_CAS), .T_CP(T_CP), .T_CSR(T_CSR),
  .T_RAS(T_RAS), .T_RASP(T_RASP), .T_ACCW(T_AA + T_CAC + T_CPA)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .dram_ras_no  (dram_ras_no),
  .dram_cas_no  (dram_cas_no),
  .dram_we_no   (dram_we_no),
  .dram_oe_no   (dram_oe_no),
  .dram_dq_oe_o (dram_dq_oe_o)
);

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
  localparam int unsigned PWR = 50, INIT = 8, REFI = 400, RP = 3, RCD = 2, ASC = 1,
                          CASP = 2, AA = 4, CAC = 3, CPA = 3, CP = 1, CSR = 1, RAS = 4,
                          RASP = 60;
  localparam int unsigned ACC = 3;  // latest of CAC, CPA, AA-ASC

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, req_we = 0, req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [21:0] req_addr = '0;
  logic [3:0] req_wd = '0, rsp_rd, dq_o, dq_i = '0;
  logic [10:0] dpins;

  always #2 clk = ~clk;

  fpm_dram_ctrl #(.T_PWRUP(PWR), .INIT_CNT(INIT), .REF_INT(REFI), .T_RP(RP), .T_RCD(RCD),
    .T_ASC(ASC), .T_CAS(CASP), .T_AA(AA), .T_CAC(CAC), .T_CPA(CPA), .T_CP(CP),
    .T_CSR(CSR), .T_RAS(RAS), .T_RASP(RASP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wd),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rd), .dram_addr_o(dpins),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i));

  // behavioural DRAM model
  logic [3:0] mem [logic [21:0]];
  logic [10:0] m_row, m_col;
  int cyc, cbr, ras_falls, pwr_err, pre_err, init_err, ew_err, fight_err, weh_err;
  int hi, lo, lo_max, gap, gap_max, casc;
  logic ras_q, cas_q, we_q, oe_q;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc = 0; cbr = 0; ras_falls = 0; pwr_err = 0; pre_err = 0; init_err = 0; ew_err = 0;
      fight_err = 0; weh_err = 0; hi = 0; lo = 0; lo_max = 0; gap = 0; gap_max = 0;
      casc = 0; ras_q = 1; cas_q = 1; we_q = 1; oe_q = 1; m_row = '0; m_col = '0;
    end else begin
      if (!oe_n && dq_oe) fight_err++;
      if ((ras_q && !ras_n) || (cas_q && !cas_n)) if (cyc < PWR) pwr_err++;
      if (ras_q && !ras_n) begin
        ras_falls++;
        if (hi < RP) pre_err++;
        if (!cas_n) begin
          cbr++;
          if (cbr > INIT + 1 && gap > gap_max) gap_max = gap;
          gap = 0;
        end else begin
          m_row = dpins;
          if (cbr < INIT) init_err++;
        end
      end
      if (!ras_n && cas_q && !cas_n) begin
        m_col = dpins; casc = 1;
        if (!we_n) begin
          if (we_q || !dq_oe) ew_err++;
          mem[{m_row, m_col}] = dq_o;
        end
      end else if (!cas_n) casc++;
      else casc = 0;
      if (!ras_n && !cas_q && cas_n && !oe_q && !we_n) weh_err++;
      hi = ras_n ? hi + 1 : 0;
      lo = ras_n ? 0 : lo + 1;
      if (lo > lo_max) lo_max = lo;
      if (cbr >= INIT) gap++;
      cyc++;
      ras_q = ras_n; cas_q = cas_n; we_q = we_n; oe_q = oe_n;
    end
  end

  always @(negedge clk) begin
    if (!ras_n && !cas_n && !oe_n && we_n) begin
      logic [3:0] d;
      d = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 4'h0;
      dq_i = (casc >= ACC - 1) ? d : ~d;
    end else dq_i = '0;
  end

  int compared = 0, mismatched = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [21:0] a, input logic [3:0] wd,
                        output logic [3:0] rd);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wd = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = '0;
    if (!we) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rd;
      @(negedge clk);
      check(!rsp_valid, "R7 valid pulse", int'(rsp_valid), 0);
    end
  endtask

  localparam logic [21:0] A0 = {11'h123, 11'h045}, A1 = {11'h123, 11'h046},
                          A2 = {11'h7ff, 11'h045}, A3 = {11'h000, 11'h7ff};
  // {we, addr, wdata, expected read}
  localparam logic [30:0] VEC [10] = '{
    {1'b1, A0, 4'h5, 4'h0}, {1'b1, A1, 4'ha, 4'h0}, {1'b1, A2, 4'h3, 4'h0},
    {1'b1, A3, 4'hc, 4'h0}, {1'b0, A0, 4'h0, 4'h5}, {1'b0, A1, 4'h0, 4'ha},
    {1'b0, A2, 4'h0, 4'h3}, {1'b0, A3, 4'h0, 4'hc}, {1'b1, A0, 4'hf, 4'h0},
    {1'b0, A0, 4'h0, 4'hf}};

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [3:0] rd;
    int rf0, c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    check(!dq_oe && !req_ready && !rsp_valid, "R1 idle", {dq_oe, req_ready, rsp_valid}, 0);
    rst_ni = 1;
    @(negedge clk);
    check(ras_n && cas_n && !req_ready, "R1 after release", {ras_n, cas_n, req_ready}, 6);
    while (!req_ready) @(negedge clk);
    check(cbr == INIT, "R3 init refresh count", cbr, INIT);
    check(init_err == 0, "R3 row before init", init_err, 0);
    check(pwr_err == 0 && cyc > PWR, "R2 power-up pause", pwr_err, 0);

    foreach (VEC[i]) begin
      do_req(VEC[i][30], VEC[i][29:8], VEC[i][7:4], rd);
      if (!VEC[i][30]) check(rd == VEC[i][3:0], "R4 R8 read data", rd, VEC[i][3:0]);
    end

    // page hit / miss just after a refresh, so none intervenes
    c0 = cbr;
    while (cbr == c0) @(negedge clk);
    do_req(0, A0, 0, rd);
    rf0 = ras_falls;
    do_req(0, A1, 0, rd);
    check(ras_falls == rf0, "R9 page hit no RAS", ras_falls, rf0);
    check(rd == 4'ha, "R9 hit data", rd, 10);
    do_req(0, A2, 0, rd);
    check(ras_falls == rf0 + 1, "R10 page miss reopen", ras_falls, rf0 + 1);
    check(rd == 4'h3, "R10 miss data", rd, 3);
    check(pre_err == 0, "R10 precharge", pre_err, 0);

    c0 = cbr;
    repeat (3 * REFI) @(negedge clk);
    check(cbr >= c0 + 2, "R11 periodic refresh", cbr - c0, 2);
    check(gap_max <= REFI + 40, "R11 refresh gap", gap_max, REFI + 40);
    check(!req_ready || cas_n, "R11 ready vs refresh", 0, 0);

    for (int k = 0; k < 40; k++) begin
      do_req(0, k[0] ? A1 : A0, 0, rd);
      if (k == 39) check(rd == (k[0] ? 4'ha : 4'hf), "R12 data under limit", rd, 10);
    end
    do_req(1, A3, 4'h6, rd);
    do_req(0, A3, 0, rd);
    check(rd == 4'h6, "R5 write then read", rd, 6);
    check(lo_max <= RASP, "R12 RAS low max", lo_max, RASP);
    check(fight_err == 0, "R6 OE vs drive", fight_err, 0);
    check(ew_err == 0, "R5 early write", ew_err, 0);
    check(weh_err == 0, "R7 WE hold on read", weh_err, 0);
    check(init_err == 0, "R3 late row check", init_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule